// File: doc/BRIEF.md
# Two-Bit Calculator with Scanned Seven-Segment Readout

This block takes two 2-bit unsigned operands from a bank of four switches and forms four results at once: their sum, the magnitude of their difference, their product and their integer quotient. Each result belongs to one digit of a four-digit, time-multiplexed seven-segment display. A digit shows its result only while the push button paired with it is held. With the button released, the digit is blank.

A free-running counter picks which digit is lit. Two adjacent counter bits select the digit, so the refresh rate is set by which bit pair is tapped. The digit select and the code shown on it are registered together on the same edge. Two indicator outputs also follow the switches. One flags a negative difference. The other flags a zero divisor.

Top module: `calc2_display`

## Requirements
- R1: While `rst_n` is low, the outputs are forced at once to the following values: `dig_sel_n` = 1111, `seg` = 8'hFF, and `neg_led` = `dz_led` = 0.
- R2: After reset, `dig_sel_n` has exactly one low bit. It steps through 1110, 1101, 1011, 0111 and then repeats. Each pattern is held for 2^SEL_LSB clock cycles.
- R3: The digit whose `dig_sel_n` bit k is low is paired with `btn[k]`. Digit 0 carries the quotient, digit 1 the product, digit 2 the difference and digit 3 the sum. The first operand A is `sw[3:2]` and the second operand B is `sw[1:0]`.
- R4: With `btn[3]` held, digit 3 shows A+B.
- R5: With `btn[2]` held, digit 2 shows |A−B|. `neg_led` is high exactly when A < B.
- R6: With `btn[1]` held, digit 1 shows A×B.
- R7: With `btn[0]` held, digit 0 shows floor(A/B), or 0 when B = 0. `dz_led` is high exactly when B = 0.
- R8: A digit whose button is released shows blank code 10, which means all segments are off (`seg` = 8'hFF), whatever the operands are.
- R9: The decimal point `seg[0]` is always 1, which means it is off.
- R10: Segments are active low, with `seg[7:1]` = a,b,c,d,e,f,g. Codes 0–9 give the usual decimal glyphs (for example, 8 gives 8'h01 and 1 gives 8'h9F). Codes 10–15 give all segments off.
- R11: A change on `sw` or `btn` reaches the outputs one clock edge later. The indicators do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn | input | 4 | Hold buttons; bit k enables digit k |
| sw | input | 4 | Operands: A = sw[3:2], B = sw[1:0] |
| dig_sel_n | output | 4 | Active-low digit enables |
| seg | output | 8 | Active-low segments a..g in [7:1], decimal point in [0] |
| neg_led | output | 1 | High when A < B |
| dz_led | output | 1 | High when B is zero |

## Verification
The operand pairs cover zero on either side, equal operands, A above and below B, and the largest values. These cases separate the magnitude path from a signed wrap, the zero-divisor rule from true division, and the product's maximum of 9 from truncation. The button patterns are all held, alternating pairs, none held, and single buttons. Each pattern is watched over a full scan round, which exposes a swapped digit pairing or a leak of one result onto another digit. Separate tests show that asserting reset forces the outputs at once, and that a switch change reaches the indicators on the next edge and not before it.

// File: rtl/calc2_pkg.sv
`timescale 1ns/1ps
package calc2_pkg;
  parameter int OP_W    = 2;
  parameter int RES_W   = 4;
  parameter int NUM_DIG = 4;
  parameter int SEG_W   = 7;
  localparam int SEL_W  = $clog2(NUM_DIG);

  localparam logic [RES_W-1:0] BLANK_CODE = RES_W'(10);

  typedef enum logic [SEL_W-1:0] {
    DIG_QUO = 2'd0,
    DIG_PRD = 2'd1,
    DIG_DIF = 2'd2,
    DIG_SUM = 2'd3
  } dig_e;

  typedef logic [NUM_DIG-1:0][RES_W-1:0] res_vec_t;
endpackage

// File: rtl/calc2_rst_sync.sv
`timescale 1ns/1ps
module calc2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/calc2_alu.sv
`timescale 1ns/1ps
module calc2_alu
  import calc2_pkg::*;
(
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output res_vec_t        res,
  output logic            neg,
  output logic            dz
);
  logic [RES_W-1:0] a_x;
  logic [RES_W-1:0] b_x;
  logic             b_zero;
  logic             a_lt_b;

  always_comb begin
    a_x    = RES_W'(op_a);
    b_x    = RES_W'(op_b);
    b_zero = (op_b == '0);
    a_lt_b = (op_a < op_b);

    res          = '0;
    res[DIG_SUM] = a_x + b_x;
    res[DIG_DIF] = a_lt_b ? (b_x - a_x) : (a_x - b_x);
    res[DIG_PRD] = a_x * b_x;
    res[DIG_QUO] = b_zero ? '0 : (a_x / b_x);

    neg = a_lt_b;
    dz  = b_zero;
  end
endmodule

// File: rtl/calc2_scan.sv
`timescale 1ns/1ps
module calc2_scan
  import calc2_pkg::*;
#(
  parameter int CNT_W   = 23,
  parameter int SEL_LSB = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DIG-1:0] btn,
  input  res_vec_t           res,
  output logic [RES_W-1:0]   code_q,
  output logic [NUM_DIG-1:0] dig_sel_q
);
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_d;
  logic [SEL_W-1:0]   sel;
  logic [RES_W-1:0]   code_d;
  logic [NUM_DIG-1:0] dig_sel_d;
  logic               scan_en;

  always_comb begin
    scan_en = 1'b1;
    cnt_d   = cnt_q + 1'b1;
    sel     = cnt_q[SEL_LSB +: SEL_W];
    code_d  = btn[sel] ? res[sel] : BLANK_CODE;
  end

  for (genvar k = 0; k < NUM_DIG; k++) begin : g_sel
    assign dig_sel_d[k] = (sel != SEL_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      code_q    <= BLANK_CODE;
      dig_sel_q <= '1;
    end else if (scan_en) begin
      cnt_q     <= cnt_d;
      code_q    <= code_d;
      dig_sel_q <= dig_sel_d;
    end
  end

  // R2: at most one digit enabled at any time
  a_r2_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig_sel_q));

  // R2: the enabled digit either holds or moves to the next one
  a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel_q != '1) |=> ((dig_sel_q == $past(dig_sel_q)) ||
      (dig_sel_q == {$past(dig_sel_q[NUM_DIG-2:0]), $past(dig_sel_q[NUM_DIG-1])})));

  // R8: released button gives the blank code on the next edge
  a_r8_blank_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn[sel]) |=> (code_q == BLANK_CODE));
endmodule

// File: rtl/calc2_seg_dec.sv
`timescale 1ns/1ps
module calc2_seg_dec
  import calc2_pkg::*;
(
  input  logic [RES_W-1:0] code,
  output logic [SEG_W-1:0] seg_n
);
  logic [SEG_W-1:0] lit;

  always_comb begin
    unique case (code)
      RES_W'(0): lit = 7'b1111110;
      RES_W'(1): lit = 7'b0110000;
      RES_W'(2): lit = 7'b1101101;
      RES_W'(3): lit = 7'b1111001;
      RES_W'(4): lit = 7'b0110011;
      RES_W'(5): lit = 7'b1011011;
      RES_W'(6): lit = 7'b1011111;
      RES_W'(7): lit = 7'b1110000;
      RES_W'(8): lit = 7'b1111111;
      RES_W'(9): lit = 7'b1111011;
      default:   lit = '0;
    endcase
    seg_n = ~lit;
  end
endmodule

// File: rtl/calc2_display.sv
`timescale 1ns/1ps
module calc2_display
  import calc2_pkg::*;
#(
  parameter int CNT_W       = 23,
  parameter int SEL_LSB     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DIG-1:0] btn,
  input  logic [2*OP_W-1:0]  sw,
  output logic [NUM_DIG-1:0] dig_sel_n,
  output logic [SEG_W:0]     seg,
  output logic               neg_led,
  output logic               dz_led
);
  logic             rst_s;
  logic [OP_W-1:0]  op_a;
  logic [OP_W-1:0]  op_b;
  res_vec_t         res;
  logic             neg_d;
  logic             dz_d;
  logic [RES_W-1:0] code_q;
  logic [SEG_W-1:0] seg_n;

  assign op_a = sw[2*OP_W-1:OP_W];
  assign op_b = sw[OP_W-1:0];

  calc2_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  calc2_alu i_alu (
    .op_a (op_a),
    .op_b (op_b),
    .res  (res),
    .neg  (neg_d),
    .dz   (dz_d)
  );

  calc2_scan #(.CNT_W(CNT_W), .SEL_LSB(SEL_LSB)) i_scan (
    .clk       (clk),
    .rst_n     (rst_s),
    .btn       (btn),
    .res       (res),
    .code_q    (code_q),
    .dig_sel_q (dig_sel_n)
  );

  calc2_seg_dec i_dec (
    .code  (code_q),
    .seg_n (seg_n)
  );

  assign seg = {seg_n, 1'b1};

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      neg_led <= 1'b0;
      dz_led  <= 1'b0;
    end else begin
      neg_led <= neg_d;
      dz_led  <= dz_d;
    end
  end

  // R5: sign indicator follows A < B one edge later
  a_r5_sign_led: assert property (@(posedge clk) disable iff (!rst_s)
    rst_s |=> (neg_led == ($past(op_a) < $past(op_b))));

  // R7: zero-divisor indicator follows B == 0 one edge later
  a_r7_dz_led: assert property (@(posedge clk) disable iff (!rst_s)
    rst_s |=> (dz_led == ($past(op_b) == '0)));
endmodule

// File: tb/test_calc2_display.sv
`timescale 1ns/1ps
module test_calc2_display;
  localparam int SEL_LSB = 2;
  localparam int DWELL   = 1 << SEL_LSB;
  localparam int ROUND   = 4 * DWELL;
  localparam int WD_CYC  = 20000;
  localparam int NVEC    = 11;

  // {btn, sw, sum, dif, prd, quo, neg, dz}
  localparam logic [25:0] VECS [NVEC] = '{
    {4'hF, 4'b0000, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1},
    {4'hF, 4'b1110, 4'd5, 4'd1, 4'd6, 4'd1, 1'b0, 1'b0},
    {4'hF, 4'b0111, 4'd4, 4'd2, 4'd3, 4'd0, 1'b1, 1'b0},
    {4'hF, 4'b1111, 4'd6, 4'd0, 4'd9, 4'd1, 1'b0, 1'b0},
    {4'hF, 4'b1101, 4'd4, 4'd2, 4'd3, 4'd3, 1'b0, 1'b0},
    {4'hF, 4'b1100, 4'd3, 4'd3, 4'd0, 4'd0, 1'b0, 1'b1},
    {4'h5, 4'b1010, 4'd4, 4'd0, 4'd4, 4'd1, 1'b0, 1'b0},
    {4'hA, 4'b0011, 4'd3, 4'd3, 4'd0, 4'd0, 1'b1, 1'b0},
    {4'h0, 4'b1111, 4'd6, 4'd0, 4'd9, 4'd1, 1'b0, 1'b0},
    {4'h8, 4'b1001, 4'd3, 4'd1, 4'd2, 4'd2, 1'b0, 1'b0},
    {4'h2, 4'b0110, 4'd3, 4'd1, 4'd2, 4'd0, 1'b1, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic [3:0] btn;
  logic [3:0] sw;
  logic [3:0] dig_sel_n;
  logic [7:0] seg;
  logic       neg_led;
  logic       dz_led;

  int n_cmp;
  int n_bad;

  calc2_display #(.CNT_W(6), .SEL_LSB(SEL_LSB)) i_calc2_display (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn       (btn),
    .sw        (sw),
    .dig_sel_n (dig_sel_n),
    .seg       (seg),
    .neg_led   (neg_led),
    .dz_led    (dz_led)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] glyph(input logic [3:0] code);
    logic [6:0] lit;
    case (code)
      4'd0: lit = 7'b1111110;
      4'd1: lit = 7'b0110000;
      4'd2: lit = 7'b1101101;
      4'd3: lit = 7'b1111001;
      4'd4: lit = 7'b0110011;
      4'd5: lit = 7'b1011011;
      4'd6: lit = 7'b1011111;
      4'd7: lit = 7'b1110000;
      4'd8: lit = 7'b1111111;
      4'd9: lit = 7'b1111011;
      default: lit = 7'b0000000;
    endcase
    return {~lit, 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [25:0] e);
    logic [3:0] res [4];
    int         seen [4];
    logic [3:0] prev;
    int         k;
    res[0] = e[5:2];
    res[1] = e[9:6];
    res[2] = e[13:10];
    res[3] = e[17:14];
    for (int i = 0; i < 4; i++) seen[i] = 0;
    btn = e[25:22];
    sw  = e[21:18];
    @(negedge clk);
    chk("R5 neg_led", neg_led, e[1]);
    chk("R7 dz_led", dz_led, e[0]);
    chk("R9 decimal point", seg[0], 1'b1);
    prev = dig_sel_n;
    for (int c = 0; c < ROUND; c++) begin
      case (dig_sel_n)
        4'b1110: k = 0;
        4'b1101: k = 1;
        4'b1011: k = 2;
        4'b0111: k = 3;
        default: k = -1;
      endcase
      if (k < 0) begin
        chk("R2 digit pattern", dig_sel_n, 4'b1110);
      end else begin
        seen[k]++;
        if (dig_sel_n != prev)
          chk("R2 scan order", dig_sel_n, {prev[2:0], prev[3]});
        if (!btn[k])
          chk("R8 released digit blank", seg, 8'hFF);
        else case (k)
          0: chk("R3 R7 R10 quotient digit", seg, glyph(res[0]));
          1: chk("R3 R6 R10 product digit", seg, glyph(res[1]));
          2: chk("R3 R5 R10 difference digit", seg, glyph(res[2]));
          default: chk("R3 R4 R10 sum digit", seg, glyph(res[3]));
        endcase
      end
      prev = dig_sel_n;
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) chk("R2 dwell per digit", seen[i], DWELL);
  endtask

  initial begin
    #(WD_CYC * 4);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    btn   = 4'h0;
    sw    = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 reset dig_sel_n", dig_sel_n, 4'hF);
    chk("R1 reset seg", seg, 8'hFF);
    chk("R1 reset leds", {neg_led, dz_led}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++) run_vec(VECS[v]);

    // R11: indicators move on the edge after a switch change, not before
    btn = 4'h0;
    sw  = 4'b0001;
    repeat (2) @(negedge clk);
    chk("R11 settled leds", {neg_led, dz_led}, 2'b10);
    sw = 4'b0100;
    #1;
    chk("R11 no change before edge", {neg_led, dz_led}, 2'b10);
    @(negedge clk);
    chk("R11 change after one edge", {neg_led, dz_led}, 2'b01);

    // R1: reset in mid-run forces outputs without a clock edge
    btn = 4'hF;
    sw  = 4'b1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async dig_sel_n", dig_sel_n, 4'hF);
    chk("R1 async seg", seg, 8'hFF);
    chk("R1 async leds", {neg_led, dz_led}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(VECS[3]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule